// File: doc/BRIEF.md
# Parking Occupancy Counter with Entry Lock

This block keeps a running count of the cars inside a parking area. Each
sensor at the entry gate and the exit gate delivers a one-cycle pulse per car.
The block adds one to the occupancy for an arrival and subtracts one for a
departure. It presents the current occupancy together with a lock signal that
keeps the entry door shut while the area is full.

The counter saturates at both ends. An arrival seen while the area is already
full is dropped, and so is a departure seen while it is empty. An arrival and a
departure in the same cycle cancel each other. The lock is decoded from the
registered count, so it changes in the same cycle as the count. The capacity is
a parameter and defaults to 32 cars. The count register is made wide enough to
hold the full capacity value, which is 6 bits at the default.

Top module: `occ_park_counter`

## Requirements
- R1: A synchronous active-high reset sets the occupancy to 0 and releases the lock (entry_lock = 0) at the next clock edge.
- R2: With car_in high, car_out low and occupancy below capacity at a clock edge, occupancy increases by exactly one at that edge.
- R3: With car_out high, car_in low and occupancy above 0 at a clock edge, occupancy decreases by exactly one at that edge.
- R4: With car_in and car_out both high at a clock edge, occupancy is unchanged, and this applies at any occupancy, including 0 and capacity.
- R5: A car_in pulse while occupancy equals capacity (32) is ignored. Occupancy stays at 32 and never exceeds it.
- R6: A car_out pulse while occupancy is 0 is ignored. Occupancy stays at 0 and never wraps to a high value.
- R7: entry_lock is 1 exactly when occupancy equals capacity (32) and is 0 for every occupancy from 0 to 31.
- R8: With neither pulse present, occupancy holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_in | input | 1 | One-cycle pulse per car passing the entry sensor |
| car_out | input | 1 | One-cycle pulse per car passing the exit sensor |
| occupancy | output | 6 | Current number of cars inside, 0 to capacity |
| entry_lock | output | 1 | 1 keeps the entry door locked because the area is full |

## Verification
A pulse sampled at a rising edge changes occupancy at that same edge. The entry
lock is decoded from the registered count, so it follows the count within that
cycle and shows no extra delay. The bench therefore drives the pulses on the
falling edge and samples both outputs a few nanoseconds after the next rising
edge. At that point it compares them with a reference model advanced by one
step. Each sample is tagged with the requirement its input case exercises,
whether that is saturation at full, saturation at empty, simultaneous events,
or plain counting.

// File: rtl/occ_park_pkg.sv
package occ_park_pkg;

    localparam int DEF_CAPACITY = 32;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic full;
        logic empty;
    } bound_t;

    function automatic step_e pick_step(input logic arrive,
                                        input logic depart,
                                        input bound_t edge_flags);
        step_e s;
        s = STEP_HOLD;
        if (arrive && !depart && !edge_flags.full)
            s = STEP_UP;
        else if (depart && !arrive && !edge_flags.empty)
            s = STEP_DOWN;
        return s;
    endfunction

endpackage

// File: rtl/occ_bound_detect.sv
module occ_bound_detect
    import occ_park_pkg::*;
#(
    parameter int CAPACITY = DEF_CAPACITY,
    localparam int CNT_W = $clog2(CAPACITY + 1)
) (
    input  logic [CNT_W-1:0] count,
    output bound_t           flags
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

    always_comb begin
        flags.full  = (count == CAP_V);
        flags.empty = (count == '0);
    end
endmodule

// File: rtl/occ_step_decode.sv
module occ_step_decode
    import occ_park_pkg::*;
(
    input  logic   arrive,
    input  logic   depart,
    input  bound_t flags,
    output step_e  step
);
    always_comb step = pick_step(arrive, depart, flags);
endmodule

// File: rtl/occ_sat_counter.sv
module occ_sat_counter
    import occ_park_pkg::*;
#(
    parameter int CAPACITY = DEF_CAPACITY,
    localparam int CNT_W = $clog2(CAPACITY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (step)
                STEP_UP:   count <= count + CNT_W'(1);
                STEP_DOWN: count <= count - CNT_W'(1);
                default:   count <= count;
            endcase
        end
    end
endmodule

// File: rtl/occ_park_counter.sv
module occ_park_counter
    import occ_park_pkg::*;
#(
    parameter int CAPACITY = DEF_CAPACITY,
    localparam int CNT_W = $clog2(CAPACITY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             car_in,
    input  logic             car_out,
    output logic [CNT_W-1:0] occupancy,
    output logic             entry_lock
);
    bound_t           flags;
    step_e            step;
    logic [CNT_W-1:0] count;

    occ_bound_detect #(.CAPACITY(CAPACITY)) u_bound (
        .count (count),
        .flags (flags)
    );

    occ_step_decode u_decode (
        .arrive (car_in),
        .depart (car_out),
        .flags  (flags),
        .step   (step)
    );

    occ_sat_counter #(.CAPACITY(CAPACITY)) u_count (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .count (count)
    );

    assign occupancy  = count;
    assign entry_lock = flags.full;
endmodule

// File: rtl/occ_park_counter_chk.sv
module occ_park_counter_chk #(
    parameter int CAPACITY = 32,
    localparam int CNT_W = $clog2(CAPACITY + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             car_in,
    input logic             car_out,
    input logic [CNT_W-1:0] occupancy,
    input logic             entry_lock
);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (occupancy == '0) && !entry_lock);

    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (car_in && !car_out && occupancy != CAP_V)
        |=> occupancy == $past(occupancy) + CNT_W'(1));

    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (car_out && !car_in && occupancy != '0)
        |=> occupancy == $past(occupancy) - CNT_W'(1));

    a_r4_cancel: assert property (@(posedge clk) disable iff (rst)
        (car_in && car_out) |=> $stable(occupancy));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CAP_V);

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (car_out && !car_in && occupancy == '0) |=> occupancy == '0);

    a_r7_lock_needs_arrival: assert property (@(posedge clk) disable iff (rst)
        $rose(entry_lock) |-> $past(car_in));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!car_in && !car_out) |=> $stable(occupancy));
endmodule

bind occ_park_counter occ_park_counter_chk #(.CAPACITY(CAPACITY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .car_in     (car_in),
    .car_out    (car_out),
    .occupancy  (occupancy),
    .entry_lock (entry_lock)
);

// File: tb/occ_park_counter_tb.sv
module occ_park_counter_tb;
    localparam int CAP = 32;
    localparam int W   = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         car_in = 1'b0;
    logic         car_out = 1'b0;
    logic [W-1:0] occupancy;
    logic         entry_lock;

    int tests = 0;
    int fails = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    occ_park_counter #(.CAPACITY(CAP)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .car_in     (car_in),
        .car_out    (car_out),
        .occupancy  (occupancy),
        .entry_lock (entry_lock)
    );

    function automatic int model_next(int c, logic i, logic o);
        if (i && !o && c < CAP) return c + 1;
        if (o && !i && c > 0)   return c - 1;
        return c;
    endfunction

    function automatic string req_of(int c, logic i, logic o);
        if (i && o)             return "R4";
        if (i && c == CAP)      return "R5";
        if (o && c == 0)        return "R6";
        if (i)                  return "R2";
        if (o)                  return "R3";
        return "R8";
    endfunction

    task automatic check(string tag, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check(tag, int'(occupancy), exp_cnt);
        check("R7", int'(entry_lock), (exp_cnt == CAP) ? 1 : 0);
    endtask

    task automatic drive(logic i, logic o);
        string tag;
        @(negedge clk);
        car_in  = i;
        car_out = o;
        tag = req_of(exp_cnt, i, o);
        @(posedge clk);
        #5;
        exp_cnt = model_next(exp_cnt, i, o);
        check_outputs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        car_in = 1'b0;
        car_out = 1'b0;
        @(posedge clk);
        #5;
        exp_cnt = 0;
        check_outputs("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        int bias;
        seed = 32'h1234_abcd;
        void'($urandom(seed));
        repeat (2) @(posedge clk);
        do_reset();

        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        for (int k = 0; k < CAP; k++) drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b0);
        for (int k = 0; k < CAP + 2; k++) drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        for (int k = 0; k < 10; k++) drive(1'b1, 1'b0);
        do_reset();

        for (int ph = 0; ph < 12; ph++) begin
            bias = (ph % 2 == 0) ? 75 : 25;
            for (int k = 0; k < 150; k++) begin
                int r;
                logic i;
                logic o;
                r = $urandom_range(99);
                i = (r < bias);
                o = ($urandom_range(99) >= bias);
                if ($urandom_range(9) == 0) begin
                    i = 1'b0;
                    o = 1'b0;
                end
                drive(i, o);
            end
        end
        do_reset();
        drive(1'b1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule